// File: doc/BRIEF.md
# Registered 16-Operation Datapath ALU

This block is the arithmetic and logic unit of a small processor datapath. Each cycle it takes a left operand, a right operand and a 4-bit operation code. It computes one of sixteen fixed functions and registers the result word together with five status flags. The operations are:

- arithmetic: add, subtract, and increment or decrement of either operand;
- bitwise: AND, OR and NOT;
- one-bit moves: a left shift and a right rotate;
- selection: pass either operand unchanged, or drive all zeros or all ones;
- an idle code.

The result and the flags appear one clock after the inputs are presented. The flags tell the surrounding sequencer whether the result is zero or negative, whether an unsigned carry or borrow left the word, whether the signed range was exceeded, and which bit a shift or rotate pushed out. The word width is a parameter with a default of 16. All encodings below assume that default.

Top module: `alu16_core`

## Requirements
- R1: The result and all flags are registered. The outputs for inputs presented before a rising clock edge are visible after that edge. An active-low asynchronous reset clears the result and all five flags to 0.
- R2: The operation code encodes as follows: 0 idle, 1 add, 2 subtract, 3 increment left, 4 increment right, 5 decrement left, 6 decrement right, 7 AND, 8 OR, 9 invert left, 10 shift left, 11 rotate right, 12 pass left, 13 pass right, 14 all zeros, 15 all ones.
- R3: Add yields L+R modulo 2^16, with flag bit 2 set on unsigned carry out. Subtract yields L-R modulo 2^16, with flag bit 2 set when L < R unsigned (borrow).
- R4: Increment yields the chosen operand plus 1, with flag bit 2 set when that operand was 0xFFFF. Decrement yields the chosen operand minus 1, with flag bit 2 set when that operand was 0x0000.
- R5: For the six arithmetic codes (1 to 6), flag bit 3 is set exactly when the two's-complement result is out of signed range.
- R6: AND yields L&R, OR yields L|R, and invert yields ~L.
- R7: Shift left yields L<<1 with a 0 entering bit 0, and flag bit 4 equals the old L[15]. Rotate right yields {L[0],L[15:1]}, and flag bit 4 equals the old L[0].
- R8: Pass left yields L, pass right yields R, code 14 yields 0x0000 and code 15 yields 0xFFFF.
- R9: The idle code yields a result of 0 with all five flags at 0, including the zero flag.
- R10: For every code except idle, flag bit 0 is set exactly when the result is 0, and flag bit 1 equals result bit 15.
- R11: Flag bits 2 and 3 are 0 for every non-arithmetic code. Flag bit 4 is 0 for every code other than shift left and rotate right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| lhs_i | input | 16 | Left operand |
| rhs_i | input | 16 | Right operand |
| res_o | output | 16 | Registered result word |
| flags_o | output | 5 | Registered flags: bit0 zero, bit1 negative, bit2 carry/borrow, bit3 signed overflow, bit4 bit shifted out |

## Verification
The bench builds the block at its default 16-bit width. At that width, every code can be driven with the signed and unsigned boundary words 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF, which are the operands at which carry, borrow and signed overflow change state. Every code is swept over all pairs of these boundary words and then over random operands. Every registered result and flag is compared with a behavioural model one cycle later. A reset in the middle of the run confirms that the registered state clears.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    // Operation codes; the numeric order is the instruction encoding
    typedef enum logic [3:0] {
        OP_IDLE  = 4'd0,
        OP_SUM   = 4'd1,
        OP_DIFF  = 4'd2,
        OP_INCL  = 4'd3,
        OP_INCR  = 4'd4,
        OP_DECL  = 4'd5,
        OP_DECR  = 4'd6,
        OP_AND   = 4'd7,
        OP_OR    = 4'd8,
        OP_INVL  = 4'd9,
        OP_SHL   = 4'd10,
        OP_RORR  = 4'd11,
        OP_PASSL = 4'd12,
        OP_PASSR = 4'd13,
        OP_ZERO  = 4'd14,
        OP_ONES  = 4'd15
    } alu_op_e;

    localparam int FLAG_W = 5;

    // Packed so that bit 0 is zero and bit 4 is the moved-out bit
    typedef struct packed {
        logic shout;
        logic ovf;
        logic cy;
        logic neg;
        logic zero;
    } alu_flags_t;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   lhs,
    input  logic [W-1:0]   rhs,
    output logic [W-1:0]   sum,
    output logic           cy,
    output logic           ovf,
    output logic           is_arith
);

    localparam int WX = W + 1;

    logic [W-1:0]  opa;
    logic [W-1:0]  opb;
    logic          cin;
    logic          flip_cy;
    logic [WX-1:0] wide;

    // One adder serves every arithmetic code; operands are steered in
    always_comb begin
        opa      = lhs;
        opb      = '0;
        cin      = 1'b0;
        flip_cy  = 1'b0;
        is_arith = 1'b1;
        case (op)
            OP_SUM:  opb = rhs;
            OP_DIFF: begin opb = ~rhs; cin = 1'b1; flip_cy = 1'b1; end
            OP_INCL: cin = 1'b1;
            OP_INCR: begin opa = rhs; cin = 1'b1; end
            OP_DECL: begin opb = '1; flip_cy = 1'b1; end
            OP_DECR: begin opa = rhs; opb = '1; flip_cy = 1'b1; end
            default: is_arith = 1'b0;
        endcase
    end

    assign wide = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
    assign sum  = wide[W-1:0];
    // A missing carry on a subtracting path is a borrow
    assign cy   = is_arith & (wide[W] ^ flip_cy);
    assign ovf  = is_arith & (opa[W-1] == opb[W-1]) & (sum[W-1] != opa[W-1]);

endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   lhs,
    input  logic [W-1:0]   rhs,
    output logic [W-1:0]   res,
    output logic           shout
);

    always_comb begin
        res   = '0;
        shout = 1'b0;
        case (op)
            OP_AND:   res = lhs & rhs;
            OP_OR:    res = lhs | rhs;
            OP_INVL:  res = ~lhs;
            OP_SHL:   begin res = {lhs[W-2:0], 1'b0};  shout = lhs[W-1]; end
            OP_RORR:  begin res = {lhs[0], lhs[W-1:1]}; shout = lhs[0];   end
            OP_PASSL: res = lhs;
            OP_PASSR: res = rhs;
            OP_ONES:  res = '1;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          op_i,
    input  logic [W-1:0]        lhs_i,
    input  logic [W-1:0]        rhs_i,
    output logic [W-1:0]        res_o,
    output logic [FLAG_W-1:0]   flags_o
);

    typedef struct packed {
        logic [W-1:0] res;
        alu_flags_t   fl;
    } out_t;

    alu_op_e      op;
    logic [W-1:0] a_sum;
    logic         a_cy;
    logic         a_ovf;
    logic         a_sel;
    logic [W-1:0] b_res;
    logic         b_shout;
    out_t         out_d;
    out_t         out_q;

    assign op = alu_op_e'(op_i);

    alu16_addsub #(.W(W)) u_addsub (
        .op       (op),
        .lhs      (lhs_i),
        .rhs      (rhs_i),
        .sum      (a_sum),
        .cy       (a_cy),
        .ovf      (a_ovf),
        .is_arith (a_sel)
    );

    alu16_bitops #(.W(W)) u_bitops (
        .op    (op),
        .lhs   (lhs_i),
        .rhs   (rhs_i),
        .res   (b_res),
        .shout (b_shout)
    );

    always_comb begin
        out_d = '0;
        if (op != OP_IDLE) begin
            out_d.res      = a_sel ? a_sum : b_res;
            out_d.fl.zero  = (out_d.res == '0);
            out_d.fl.neg   = out_d.res[W-1];
            out_d.fl.cy    = a_cy;
            out_d.fl.ovf   = a_ovf;
            out_d.fl.shout = b_shout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o   = out_q.res;
    assign flags_o = out_q.fl;

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
    parameter int W = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_i,
    input logic [W-1:0]  lhs_i,
    input logic [W-1:0]  rhs_i,
    input logic [W-1:0]  res_o,
    input logic [4:0]    flags_o
);

    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd0 |=> (res_o == '0) && (flags_o == 5'd0));

    // R8
    pass_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd12 |=> res_o == $past(lhs_i));

    // R8
    all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd15 |=> res_o == {W{1'b1}});

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[0] |-> res_o == '0);

    // R10
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[1] |-> res_o[W-1]);

    // R11
    logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i >= 4'd7 |=> flags_o[3:2] == 2'b00);

    // R7
    shift_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd10 |=> flags_o[4] == $past(lhs_i[W-1]));

    // R6
    invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd9 |=> res_o == ~$past(lhs_i));

endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_core_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .lhs_i   (lhs_i),
    .rhs_i   (rhs_i),
    .res_o   (res_o),
    .flags_o (flags_o)
);

// File: tb/test_alu16_core.sv
`timescale 1ns/1ps
module test_alu16_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [15:0] lhs_i = 16'd0;
    logic [15:0] rhs_i = 16'd0;
    logic [15:0] res_o;
    logic [4:0]  flags_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        have_exp = 1'b0;
    logic [3:0]  exp_op;
    logic [15:0] exp_res;
    logic [4:0]  exp_fl;

    always #2 clk = ~clk;

    alu16_core i_alu16_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_i),
        .lhs_i   (lhs_i),
        .rhs_i   (rhs_i),
        .res_o   (res_o),
        .flags_o (flags_o)
    );

    function automatic string res_tag(input logic [3:0] op);
        if (op == 0) return "R9";
        if (op <= 2) return "R3";
        if (op <= 6) return "R4";
        if (op <= 9) return "R6";
        if (op <= 11) return "R7";
        return "R8";
    endfunction

    // Behavioural reference: {flags, result}
    function automatic logic [20:0] model(input logic [3:0] op,
                                          input logic [15:0] l,
                                          input logic [15:0] r);
        logic [16:0] t;
        logic [15:0] y;
        logic c, v, s;
        c = 0; v = 0; s = 0; y = 0;
        case (op)
            4'd1: begin t = {1'b0, l} + {1'b0, r}; y = t[15:0]; c = t[16];
                        v = (l[15] == r[15]) && (y[15] != l[15]); end
            4'd2: begin y = l - r; c = (l < r);
                        v = (l[15] != r[15]) && (y[15] != l[15]); end
            4'd3: begin y = l + 1; c = (l == 16'hFFFF); v = (l == 16'h7FFF); end
            4'd4: begin y = r + 1; c = (r == 16'hFFFF); v = (r == 16'h7FFF); end
            4'd5: begin y = l - 1; c = (l == 16'h0000); v = (l == 16'h8000); end
            4'd6: begin y = r - 1; c = (r == 16'h0000); v = (r == 16'h8000); end
            4'd7: y = l & r;
            4'd8: y = l | r;
            4'd9: y = ~l;
            4'd10: begin y = l << 1; s = l[15]; end
            4'd11: begin y = (l >> 1) | (l << 15); s = l[0]; end
            4'd12: y = l;
            4'd13: y = r;
            4'd14: y = 16'h0000;
            4'd15: y = 16'hFFFF;
            default: y = 16'h0000;
        endcase
        if (op == 0) return 21'd0;
        return {s, v, c, y[15], (y == 16'd0), y};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s op=%0d actual=%h expected=%h", tag, exp_op, act, exp);
        end
    endtask

    task automatic compare();
        logic ar;
        if (!have_exp) return;
        ar = (exp_op >= 1) && (exp_op <= 6);
        chk($sformatf("R2/%s result", res_tag(exp_op)), res_o, exp_res);
        chk(exp_op == 0 ? "R9 zero/neg" : "R10 zero/neg",
            {14'd0, flags_o[1:0]}, {14'd0, exp_fl[1:0]});
        chk(ar ? (exp_op <= 2 ? "R3 carry" : "R4 carry") : "R11 carry",
            {15'd0, flags_o[2]}, {15'd0, exp_fl[2]});
        chk(ar ? "R5 overflow" : "R11 overflow", {15'd0, flags_o[3]}, {15'd0, exp_fl[3]});
        chk((exp_op == 10 || exp_op == 11) ? "R7 shout" : "R11 shout",
            {15'd0, flags_o[4]}, {15'd0, exp_fl[4]});
    endtask

    task automatic apply(input logic [3:0] op, input logic [15:0] l, input logic [15:0] r);
        logic [20:0] m;
        @(negedge clk);
        compare();
        op_i = op; lhs_i = l; rhs_i = r;
        m = model(op, l, r);
        exp_op = op; exp_res = m[15:0]; exp_fl = m[20:16];
        have_exp = 1'b1;
    endtask

    task automatic chk_reset();
        exp_op = 0;
        chk("R1 reset result", res_o, 16'd0);
        chk("R1 reset flags", {11'd0, flags_o}, 16'd0);
    endtask

    logic [15:0] corner [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

    initial begin
        repeat (3) @(negedge clk);
        chk_reset();
        rst_n = 1'b1;
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    apply(op[3:0], corner[i], corner[j]);
        for (int k = 0; k < 3000; k++)
            apply(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom));
        // Mid-run reset
        apply(4'd15, 16'h1234, 16'h5678);
        @(negedge clk);
        compare();
        have_exp = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset();
        rst_n = 1'b1;
        apply(4'd1, 16'hFFFF, 16'h0001);
        apply(4'd2, 16'h0000, 16'h0001);
        apply(4'd11, 16'h0001, 16'h0000);
        @(negedge clk);
        compare();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule